// File: doc/BRIEF.md
# Character LCD Command Sequencer

This block drives an 8-bit parallel character display bus. Its lines are a register select, a read/write select, an enable strobe and eight data lines. The data lines are split into a driven output, an output enable and a sampled input, so the pad ring can build the tristate buffer. After reset the block writes a fixed start-up list of four commands on its own. After that it takes command or character bytes from an upstream valid/ready interface and writes each byte to the display.

Every transfer is paced by reading the module's busy flag, not by fixed delays. A status read is repeated until data bit 7 reads low. Only then may the next write start. Cursor placement codes are ordinary commands: the upstream side forms them and the block passes them through unchanged. The minimum enable high time and low time are parameters, counted in clock cycles.

Top module: `lcd_seq`

## Requirements
- R1: While reset is asserted, `in_ready`, `lcd_e` and `lcd_db_oe` are all low.
- R2: After reset the block writes 0x38, 0x0F, 0x06 and 0x01, in that order and all with `lcd_rs` low, before `in_ready` first goes high.
- R3: An accepted byte is written with `lcd_rw` low, `lcd_rs` equal to `in_is_char` (1 = character, 0 = command), and `lcd_db_out` equal to the byte at the falling edge of `lcd_e`.
- R4: A busy read holds `lcd_rs` low, `lcd_rw` high and `lcd_db_oe` low. It pulses `lcd_e` and is repeated for as long as `lcd_db_in[7]` reads high. The other input bits are ignored.
- R5: A write never begins unless a busy read that found bit 7 low has completed since the previous write. This includes the first write after reset.
- R6: `lcd_e` stays high for at least `E_HIGH_CYC` cycles and low for at least `E_LOW_CYC` cycles between pulses. `lcd_rs` and `lcd_rw` hold their values for at least one cycle before `lcd_e` rises, and they stay stable, together with `lcd_db_out`, while `lcd_e` is high.
- R7: A byte is accepted only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the busy read that follows that byte's write finds bit 7 low.
- R8: Cursor codes such as 0x80 + column (line 1) and 0xC0 + column (line 2) are written unchanged as commands.
- R9: `lcd_db_oe` is high only when `lcd_rw` is low, so the data lines are never driven during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream byte is valid |
| in_is_char | input | 1 | 1 = character byte, 0 = command byte |
| in_byte | input | 8 | Upstream byte |
| in_ready | output | 1 | Block can accept a byte this cycle |
| lcd_rs | output | 1 | Register select: 1 = data, 0 = command or status |
| lcd_rw | output | 1 | 1 = read, 0 = write |
| lcd_e | output | 1 | Enable strobe; a falling edge latches the byte |
| lcd_db_out | output | 8 | Data lines, driven value |
| lcd_db_oe | output | 1 | Data line output enable |
| lcd_db_in | input | 8 | Data lines, sampled value (bit 7 = busy) |

## Verification
Two functions can land in the same cycle: the busy read that ends a transfer, and the upstream offer of the next byte. The bench keeps `in_valid` high between bytes, so each new byte is waiting when `in_ready` comes back, and it is taken in the first cycle of readiness. Each byte must then appear exactly once in the display-side write log, in order and with its register select intact. The model's busy count is varied per byte, so the number of status reads after each write is checked as busy plus one.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [2:0] {
    ST_PSET,   // status read: select lines settle
    ST_PHI,    // status read: strobe high
    ST_PLO,    // status read: strobe low
    ST_WSET,   // write: select lines and data settle
    ST_WHI,    // write: strobe high
    ST_WLO,    // write: strobe low, data held
    ST_IDLE    // waiting for upstream
  } seq_st_t;

  localparam int BOOT_LEN = 4;

  // Start-up command list: function set, display control, entry mode, clear.
  function automatic logic [7:0] boot_cmd(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h38;
      2'd1:    return 8'h0F;
      2'd2:    return 8'h06;
      default: return 8'h01;
    endcase
  endfunction

  // Only the top data bit carries the busy flag.
  function automatic logic busy_bit(input logic [7:0] db);
    return db[7];
  endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] len,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (!done)   cnt_q <= cnt_q + CW'(1);
  end

  assign done = (cnt_q == len - CW'(1));
endmodule

// File: rtl/lcd_boot_list.sv
module lcd_boot_list
  import lcd_seq_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic [IW-1:0] idx,
  output logic [7:0]    cmd,
  output logic          finished
);
  assign cmd      = boot_cmd(idx[1:0]);
  assign finished = (int'(idx) >= BOOT_LEN);
endmodule

// File: rtl/lcd_bus_drive.sv
module lcd_bus_drive
  import lcd_seq_pkg::*;
(
  input  seq_st_t    st,
  input  logic       rs_hold,
  input  logic [7:0] byte_hold,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db_out,
  output logic       lcd_db_oe
);
  logic wr_phase;

  assign wr_phase   = (st == ST_WSET) || (st == ST_WHI) || (st == ST_WLO);
  assign lcd_rs     = wr_phase ? rs_hold : 1'b0;
  assign lcd_rw     = !wr_phase;
  assign lcd_db_oe  = wr_phase;
  assign lcd_db_out = wr_phase ? byte_hold : 8'h00;
  assign lcd_e      = (st == ST_PHI) || (st == ST_WHI);
endmodule

// File: rtl/lcd_seq.sv
module lcd_seq
  import lcd_seq_pkg::*;
#(
  parameter int E_HIGH_CYC = 4,
  parameter int E_LOW_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_is_char,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db_out,
  output logic       lcd_db_oe,
  input  logic [7:0] lcd_db_in
);
  localparam int PH_MAX = (E_HIGH_CYC > E_LOW_CYC) ? E_HIGH_CYC : E_LOW_CYC;
  localparam int CW     = $clog2(PH_MAX + 1);
  localparam int IW     = $clog2(BOOT_LEN + 1);

  seq_st_t       st_q, st_n;
  logic [7:0]    byte_q;
  logic          rs_q;
  logic          busy_q;
  logic [IW-1:0] boot_idx_q;
  logic [CW-1:0] ph_len;
  logic          ph_done;
  logic [7:0]    boot_byte;
  logic          boot_end;

  // Named events, also used by the checker
  logic accept;
  logic poll_clear;
  logic write_fall;

  assign in_ready   = (st_q == ST_IDLE);
  assign accept     = in_ready && in_valid;
  assign poll_clear = (st_q == ST_PLO) && ph_done && !busy_q;
  assign write_fall = (st_q == ST_WHI) && ph_done;

  always_comb begin
    case (st_q)
      ST_PHI, ST_WHI: ph_len = CW'(E_HIGH_CYC);
      ST_PLO, ST_WLO: ph_len = CW'(E_LOW_CYC);
      default:        ph_len = CW'(1);
    endcase
  end

  lcd_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (st_n != st_q),
    .len     (ph_len),
    .done    (ph_done)
  );

  lcd_boot_list #(.IW(IW)) u_boot (
    .idx      (boot_idx_q),
    .cmd      (boot_byte),
    .finished (boot_end)
  );

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_PSET: st_n = ST_PHI;
      ST_PHI:  if (ph_done) st_n = ST_PLO;
      ST_PLO: begin
        if (ph_done) begin
          if (busy_q)        st_n = ST_PSET;
          else if (boot_end) st_n = ST_IDLE;
          else               st_n = ST_WSET;
        end
      end
      ST_WSET: st_n = ST_WHI;
      ST_WHI:  if (ph_done) st_n = ST_WLO;
      ST_WLO:  if (ph_done) st_n = ST_PSET;
      ST_IDLE: if (in_valid) st_n = ST_WSET;
      default: st_n = ST_PSET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_PSET;
      byte_q     <= 8'h00;
      rs_q       <= 1'b0;
      busy_q     <= 1'b0;
      boot_idx_q <= '0;
    end else begin
      st_q <= st_n;
      if (st_q == ST_PHI && ph_done)
        busy_q <= busy_bit(lcd_db_in);
      if (poll_clear && !boot_end) begin
        byte_q     <= boot_byte;
        rs_q       <= 1'b0;
        boot_idx_q <= boot_idx_q + IW'(1);
      end
      if (accept) begin
        byte_q <= in_byte;
        rs_q   <= in_is_char;
      end
    end
  end

  lcd_bus_drive u_drive (
    .st         (st_q),
    .rs_hold    (rs_q),
    .byte_hold  (byte_q),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_e      (lcd_e),
    .lcd_db_out (lcd_db_out),
    .lcd_db_oe  (lcd_db_oe)
  );
endmodule

// File: rtl/lcd_seq_chk.sv
module lcd_seq_chk #(
  parameter int E_HIGH_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_e,
  input logic [7:0] lcd_db_out,
  input logic       lcd_db_oe,
  input logic       accept,
  input logic       poll_clear,
  input logic       write_fall
);
  logic [15:0] hi_run_q;
  logic        clear_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_run_q <= '0;
    else if (lcd_e) hi_run_q <= hi_run_q + 16'd1;
    else            hi_run_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          clear_ok_q <= 1'b0;
    else if (poll_clear) clear_ok_q <= 1'b1;
    else if (write_fall) clear_ok_q <= 1'b0;
  end

  // R1: quiet outputs in reset
  always_comb begin
    if (!rst_n) p_reset_quiet_r1: assert (!in_ready && !lcd_e && !lcd_db_oe);
  end

  p_status_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rw |-> !lcd_rs);

  p_clear_before_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lcd_e) && !lcd_rw) |-> clear_ok_q);

  p_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && $past(lcd_e)) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_db_out)));

  p_e_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> (hi_run_q >= 16'(E_HIGH_CYC)));

  p_accept_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  p_ready_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(poll_clear));

  p_no_drive_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_db_oe |-> !lcd_rw);
endmodule

bind lcd_seq lcd_seq_chk #(.E_HIGH_CYC(E_HIGH_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .lcd_rs     (lcd_rs),
  .lcd_rw     (lcd_rw),
  .lcd_e      (lcd_e),
  .lcd_db_out (lcd_db_out),
  .lcd_db_oe  (lcd_db_oe),
  .accept     (accept),
  .poll_clear (poll_clear),
  .write_fall (write_fall)
);

// File: tb/test_lcd_seq.sv
`timescale 1ns/1ps
module test_lcd_seq;
  localparam int EH = 3;
  localparam int EL = 2;
  localparam int NV = 8;
  localparam int NB = 4;
  // {busy reads, is_char, byte}
  localparam logic [12:0] VEC [NV] = '{
    {4'd0, 1'b1, 8'h48},
    {4'd3, 1'b1, 8'h69},
    {4'd1, 1'b0, 8'h85},   // line 1, column 5
    {4'd0, 1'b1, 8'h00},
    {4'd2, 1'b0, 8'hC3},   // line 2, column 3
    {4'd0, 1'b1, 8'hFF},
    {4'd5, 1'b0, 8'h01},
    {4'd0, 1'b1, 8'h7E}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_char = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
  logic [7:0] lcd_db_out, lcd_db_in;

  int total = 0, bad = 0, cyc = 0;
  int log_n = 0, rd_since = 0, acc = 0, busy_cnt = 0;
  int v4 = 0, v5 = 0, v6 = 0, v7 = 0, v9 = 0;
  bit last_rd_busy = 1'b0;
  logic lrs [16];
  logic [7:0] lbyte [16];
  int polls [16];

  always #4 clk = ~clk;

  lcd_seq #(.E_HIGH_CYC(EH), .E_LOW_CYC(EL)) i_lcd_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_char(in_is_char),
    .in_byte(in_byte), .in_ready(in_ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_e(lcd_e), .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe),
    .lcd_db_in(lcd_db_in));

  // Display model: the low bits are noise, bit 7 is busy.
  assign lcd_db_in = {busy_cnt != 0, 7'h2A};

  always @(negedge lcd_e) begin
    if (rst_n) begin
      if (!lcd_rw) begin
        if (rd_since == 0 || last_rd_busy) v5++;
        lrs[log_n]   = lcd_rs;
        lbyte[log_n] = lcd_db_out;
        polls[log_n] = 0;
        busy_cnt     = (log_n < NB) ? 1 : int'(VEC[log_n - NB][12:9]);
        log_n++;
        rd_since = 0;
      end else begin
        if (lcd_rs || lcd_db_oe) v4++;
        last_rd_busy = (busy_cnt != 0);
        if (busy_cnt != 0) busy_cnt--;
        rd_since++;
        if (log_n > 0) polls[log_n - 1] = rd_since;
      end
    end
  end

  always @(posedge clk) if (rst_n && in_valid && in_ready) acc++;

  logic p_e = 1'b0, p_rs = 1'b0, p_rw = 1'b1;
  logic [7:0] p_db = 8'h00;
  int hi_run = 0, lo_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (lcd_db_oe && lcd_rw) v9++;
      if (lcd_e && !p_e && (lcd_rs != p_rs || lcd_rw != p_rw)) v6++;
      if (lcd_e && p_e && (lcd_rs != p_rs || lcd_rw != p_rw || lcd_db_out != p_db)) v6++;
      if (!lcd_e && p_e && hi_run < EH) v6++;
      if (lcd_e && !p_e && lo_run < EL && log_n + rd_since > 0) v6++;
      hi_run = lcd_e ? hi_run + 1 : 0;
      lo_run = lcd_e ? 0 : lo_run + 1;
      if (in_ready && (acc != log_n - NB || busy_cnt != 0)) v7++;
      p_e = lcd_e; p_rs = lcd_rs; p_rw = lcd_rw; p_db = lcd_db_out;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!in_ready, "R1 in_ready", in_ready, 0);
    chk(!lcd_e, "R1 lcd_e", lcd_e, 0);
    chk(!lcd_db_oe, "R1 lcd_db_oe", lcd_db_oe, 0);
    rst_n = 1'b1;

    while (!in_ready) @(negedge clk);
    chk(log_n == NB, "R2 boot count", log_n, NB);
    for (int k = 0; k < NB; k++) begin
      logic [7:0] eb;
      eb = (k == 0) ? 8'h38 : (k == 1) ? 8'h0F : (k == 2) ? 8'h06 : 8'h01;
      chk(lbyte[k] == eb && !lrs[k], "R2 boot byte", {lrs[k], lbyte[k]}, eb);
    end

    // Table walk; valid is held so each byte waits for readiness.
    for (int i = 0; i < NV; i++) begin
      in_is_char = VEC[i][8];
      in_byte    = VEC[i][7:0];
      in_valid   = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      chk(!in_ready, "R7 ready drop", in_ready, 0);
    end
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
    repeat (10) @(negedge clk);

    chk(log_n == NB + NV, "R3 write count", log_n, NB + NV);
    chk(acc == NV, "R7 accept count", acc, NV);
    for (int i = 0; i < NV; i++) begin
      chk(lbyte[NB+i] == VEC[i][7:0] && lrs[NB+i] == VEC[i][8],
          (VEC[i][8]) ? "R3 char write" : "R8 command write",
          {lrs[NB+i], lbyte[NB+i]}, VEC[i][8:0]);
      chk(polls[NB+i] == int'(VEC[i][12:9]) + 1, "R4 read repeats",
          polls[NB+i], int'(VEC[i][12:9]) + 1);
    end
    chk(polls[0] == 2, "R4 boot read repeats", polls[0], 2);
    chk(v4 == 0, "R4 read lines", v4, 0);
    chk(v5 == 0, "R5 write after clear", v5, 0);
    chk(v6 == 0, "R6 strobe timing", v6, 0);
    chk(v7 == 0, "R7 ready window", v7, 0);
    chk(v9 == 0, "R9 no drive on read", v9, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule